// File: doc/BRIEF.md
# Low-Power Mode and Clock-Gating Controller

This controller steps a processor core between a running state and three low-power levels: idle, sleep and power-down. Each level has its own pattern for the clock enables of the CPU, the on-chip peripherals and the real-time-clock domain. Each level also has its own way out. Idle is left on any interrupt. Sleep is left only on the external interrupt pin. Power-down is left only by a reset.

The instruction decoder asks for a level through a 3-bit command. The same command can also request a software reset. Hardware and watchdog reset requests arrive on their own inputs. Any reset, from any state, returns the controller to the running state and raises a reset-active flag.

All outputs are registered. The clock enables follow the mode register one cycle late, so downstream gating cells only see clean, settled levels.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: Whenever `hw_rst_req` or `wdt_rst_req` is high at a clock edge, in any mode, `mode_stat` reads 00 and `rst_active` reads 1 after that edge. `rst_active` reads 0 after any edge at which no reset source is present.
- R2: `mode_cmd` is decoded as follows: 001 requests idle, 010 requests sleep, 011 requests power-down and 100 requests a software reset (which acts as in R1). The values 000, 101, 110 and 111 change nothing.
- R3: While idle, the clock enables are cpu=0, peripheral=1, rtc=1 and `in_gate`=0.
- R4: While in sleep, cpu=0, peripheral=0, `in_gate`=0, and the rtc enable equals `rtc_keep`.
- R5: While in power-down, cpu=0, peripheral=0, the rtc enable equals `rtc_keep`, and `in_gate`=1.
- R6: In idle, `irq_req` or `ext_irq` returns the controller to the running state at the next edge.
- R7: In sleep, only `ext_irq` wakes the controller. `irq_req` alone leaves it in sleep.
- R8: In power-down, `irq_req`, `ext_irq` and every `mode_cmd` value, including the software reset, are ignored. Only `hw_rst_req` or `wdt_rst_req` leaves this mode.
- R9: A mode command given outside the running state is dropped.
- R10: If `irq_req` or `ext_irq` is high in the same cycle as an entry command (001, 010 or 011) in the running state, the controller stays running.
- R11: `mode_stat` changes at the edge that samples the request. The clock enables and `in_gate` change one edge later.
- R12: `mode_stat` encodes the mode as 00 running, 01 idle, 10 sleep and 11 power-down.
- R13: A reset source takes precedence over any interrupt or command arriving in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| mode_cmd | input | 3 | Mode/reset command from the instruction decoder |
| irq_req | input | 1 | Internal interrupt request |
| ext_irq | input | 1 | External interrupt pin |
| hw_rst_req | input | 1 | Hardware reset request |
| wdt_rst_req | input | 1 | Watchdog reset request |
| rtc_keep | input | 1 | Keep the RTC clock running in sleep and power-down |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| rtc_clk_en | output | 1 | RTC domain clock enable |
| in_gate | output | 1 | High while inputs are disregarded (power-down) |
| rst_active | output | 1 | A reset was taken at the last edge |
| mode_stat | output | 2 | Current mode code |

## Verification
Two things can land in the same cycle and compete for the mode register: an entry command and a wake interrupt. A reset can also coincide with either of them. The bench drives an idle or sleep command together with `irq_req` or `ext_irq` in the running state, and expects `mode_stat` to stay 00. It also drives hardware and watchdog resets together with an interrupt or a command, and expects 00 with `rst_active` set. In each case the check is made on the sample after the edge that saw both inputs.

// File: rtl/pm_ctrl_pkg.sv
package pm_ctrl_pkg;

    localparam int unsigned CMD_W  = 3;
    localparam int unsigned MODE_W = 2;

    typedef enum logic [MODE_W-1:0] {
        PM_RUN   = 2'b00,
        PM_IDLE  = 2'b01,
        PM_SLEEP = 2'b10,
        PM_OFF   = 2'b11
    } pm_mode_e;

    localparam logic [CMD_W-1:0] CMD_NONE  = 3'b000;
    localparam logic [CMD_W-1:0] CMD_IDLE  = 3'b001;
    localparam logic [CMD_W-1:0] CMD_SLEEP = 3'b010;
    localparam logic [CMD_W-1:0] CMD_OFF   = 3'b011;
    localparam logic [CMD_W-1:0] CMD_SWRST = 3'b100;

    typedef struct packed {
        logic to_idle;
        logic to_sleep;
        logic to_off;
        logic soft_rst;
    } pm_cmd_t;

    typedef struct packed {
        logic cpu_en;
        logic per_en;
        logic rtc_en;
        logic in_gate;
    } pm_clk_t;

    typedef struct packed {
        pm_mode_e mode;
        logic     rst_flag;
    } pm_state_t;

    localparam pm_clk_t CLK_RUN = '{cpu_en: 1'b1, per_en: 1'b1, rtc_en: 1'b1, in_gate: 1'b0};

endpackage

// File: rtl/pm_cmd_decode.sv
module pm_cmd_decode
    import pm_ctrl_pkg::*;
(
    input  logic [CMD_W-1:0] cmd,
    output pm_cmd_t          dec
);
    always_comb begin
        dec = '0;
        case (cmd)
            CMD_IDLE:  dec.to_idle  = 1'b1;
            CMD_SLEEP: dec.to_sleep = 1'b1;
            CMD_OFF:   dec.to_off   = 1'b1;
            CMD_SWRST: dec.soft_rst = 1'b1;
            default:   dec = '0;
        endcase
    end
endmodule

// File: rtl/pm_wake_eval.sv
module pm_wake_eval
    import pm_ctrl_pkg::*;
(
    input  pm_mode_e mode,
    input  logic     irq_req,
    input  logic     ext_irq,
    output logic     wake
);
    // Each low-power level has its own wake set; power-down has none.
    always_comb begin
        case (mode)
            PM_IDLE:  wake = irq_req | ext_irq;
            PM_SLEEP: wake = ext_irq;
            default:  wake = 1'b0;
        endcase
    end
endmodule

// File: rtl/pm_clk_enc.sv
module pm_clk_enc
    import pm_ctrl_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  pm_mode_e mode,
    input  logic     rtc_keep,
    output pm_clk_t  clk_q
);
    pm_clk_t clk_d;

    always_comb begin
        clk_d = CLK_RUN;
        case (mode)
            PM_RUN:   clk_d = CLK_RUN;
            PM_IDLE:  clk_d = '{cpu_en: 1'b0, per_en: 1'b1, rtc_en: 1'b1, in_gate: 1'b0};
            PM_SLEEP: clk_d = '{cpu_en: 1'b0, per_en: 1'b0, rtc_en: rtc_keep, in_gate: 1'b0};
            PM_OFF:   clk_d = '{cpu_en: 1'b0, per_en: 1'b0, rtc_en: rtc_keep, in_gate: 1'b1};
            default:  clk_d = CLK_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) clk_q <= CLK_RUN;
        else        clk_q <= clk_d;
    end
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
    import pm_ctrl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CMD_W-1:0]  mode_cmd,
    input  logic              irq_req,
    input  logic              ext_irq,
    input  logic              hw_rst_req,
    input  logic              wdt_rst_req,
    input  logic              rtc_keep,
    output logic              cpu_clk_en,
    output logic              per_clk_en,
    output logic              rtc_clk_en,
    output logic              in_gate,
    output logic              rst_active,
    output logic [MODE_W-1:0] mode_stat
);
    pm_state_t s_d, s_q;
    pm_cmd_t   dec;
    logic      wake;
    logic      any_rst;
    logic      any_irq;
    pm_clk_t   clk_q;

    pm_cmd_decode u_dec (
        .cmd (mode_cmd),
        .dec (dec)
    );

    pm_wake_eval u_wake (
        .mode    (s_q.mode),
        .irq_req (irq_req),
        .ext_irq (ext_irq),
        .wake    (wake)
    );

    always_comb begin
        s_d     = s_q;
        any_irq = irq_req | ext_irq;
        // Software reset exists only as a command, so it counts only while running.
        any_rst = hw_rst_req | wdt_rst_req | ((s_q.mode == PM_RUN) & dec.soft_rst);
        s_d.rst_flag = any_rst;
        if (any_rst) begin
            s_d.mode = PM_RUN;
        end else begin
            case (s_q.mode)
                PM_RUN: begin
                    if (!any_irq) begin
                        if      (dec.to_idle)  s_d.mode = PM_IDLE;
                        else if (dec.to_sleep) s_d.mode = PM_SLEEP;
                        else if (dec.to_off)   s_d.mode = PM_OFF;
                    end
                end
                PM_IDLE, PM_SLEEP: begin
                    if (wake) s_d.mode = PM_RUN;
                end
                default: s_d.mode = s_q.mode;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{mode: PM_RUN, rst_flag: 1'b1};
        else        s_q <= s_d;
    end

    pm_clk_enc u_clk (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (s_q.mode),
        .rtc_keep (rtc_keep),
        .clk_q    (clk_q)
    );

    assign cpu_clk_en = clk_q.cpu_en;
    assign per_clk_en = clk_q.per_en;
    assign rtc_clk_en = clk_q.rtc_en;
    assign in_gate    = clk_q.in_gate;
    assign rst_active = s_q.rst_flag;
    assign mode_stat  = s_q.mode;
endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
module pwr_mode_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] mode_cmd,
    input logic       irq_req,
    input logic       ext_irq,
    input logic       hw_rst_req,
    input logic       wdt_rst_req,
    input logic       rtc_keep,
    input logic       cpu_clk_en,
    input logic       per_clk_en,
    input logic       rtc_clk_en,
    input logic       in_gate,
    input logic       rst_active,
    input logic [1:0] mode_stat
);
    // R1
    reset_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_rst_req || wdt_rst_req) |=> (mode_stat == 2'b00 && rst_active));

    // R8
    off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_stat == 2'b11 && !hw_rst_req && !wdt_rst_req) |=> (mode_stat == 2'b11));

    // R10
    irq_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_stat == 2'b00 && (irq_req || ext_irq) && !hw_rst_req && !wdt_rst_req &&
         (mode_cmd == 3'b001 || mode_cmd == 3'b010 || mode_cmd == 3'b011))
        |=> (mode_stat == 2'b00));

    // R3
    idle_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_stat == 2'b01) |=> (!cpu_clk_en && per_clk_en && rtc_clk_en && !in_gate));

    // R5
    off_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_stat == 2'b11) |=> (in_gate && !cpu_clk_en && !per_clk_en));

    // R7
    sleep_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_stat == 2'b10 && !ext_irq && !hw_rst_req && !wdt_rst_req) |=> (mode_stat == 2'b10));

    // R4
    sleep_rtc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_stat == 2'b10) |=> (rtc_clk_en == $past(rtc_keep) && !per_clk_en));
endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk u_chk (.*);

// File: tb/tb_pwr_mode_ctrl.sv
module tb_pwr_mode_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] mode_cmd = 3'b000;
    logic       irq_req = 1'b0, ext_irq = 1'b0, hw_rst_req = 1'b0, wdt_rst_req = 1'b0;
    logic       rtc_keep = 1'b1;
    logic       cpu_clk_en, per_clk_en, rtc_clk_en, in_gate, rst_active;
    logic [1:0] mode_stat;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    pwr_mode_ctrl dut (
        .clk(clk), .rst_n(rst_n), .mode_cmd(mode_cmd), .irq_req(irq_req),
        .ext_irq(ext_irq), .hw_rst_req(hw_rst_req), .wdt_rst_req(wdt_rst_req),
        .rtc_keep(rtc_keep), .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
        .rtc_clk_en(rtc_clk_en), .in_gate(in_gate), .rst_active(rst_active),
        .mode_stat(mode_stat)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic chk_clk(input string req, input int cpu, input int per, input int rtc, input int gate);
        chk(req, "cpu_clk_en", int'(cpu_clk_en), cpu);
        chk(req, "per_clk_en", int'(per_clk_en), per);
        chk(req, "rtc_clk_en", int'(rtc_clk_en), rtc);
        chk(req, "in_gate", int'(in_gate), gate);
    endtask

    // Called at a falling edge; drives for one rising edge, returns at the next falling edge.
    task automatic step(input logic [2:0] c, input logic i, input logic e, input logic h, input logic w);
        mode_cmd = c; irq_req = i; ext_irq = e; hw_rst_req = h; wdt_rst_req = w;
        @(posedge clk);
        @(negedge clk);
        mode_cmd = 3'b000; irq_req = 1'b0; ext_irq = 1'b0; hw_rst_req = 1'b0; wdt_rst_req = 1'b0;
    endtask

    task automatic t_reset();
        repeat (2) @(negedge clk);
        chk("R1", "mode in reset", int'(mode_stat), 0);
        chk("R1", "rst_active in reset", int'(rst_active), 1);
        chk_clk("R1", 1, 1, 1, 0);
        rst_n = 1'b1;
        step(3'b000, 0, 0, 0, 0);
        chk("R1", "rst_active after release", int'(rst_active), 0);
    endtask

    task automatic t_idle();
        step(3'b001, 0, 0, 0, 0);
        chk("R12", "idle code", int'(mode_stat), 1);
        chk("R11", "cpu_en lags state", int'(cpu_clk_en), 1);
        step(3'b000, 0, 0, 0, 0);
        chk_clk("R3", 0, 1, 1, 0);
        step(3'b000, 1, 0, 0, 0);
        chk("R6", "irq wakes idle", int'(mode_stat), 0);
        step(3'b000, 0, 0, 0, 0);
        chk("R11", "cpu_en back", int'(cpu_clk_en), 1);
        step(3'b001, 0, 0, 0, 0);
        step(3'b000, 0, 1, 0, 0);
        chk("R6", "ext wakes idle", int'(mode_stat), 0);
        step(3'b000, 0, 0, 0, 0);
    endtask

    task automatic t_sleep(input logic keep);
        rtc_keep = keep;
        step(3'b010, 0, 0, 0, 0);
        chk("R12", "sleep code", int'(mode_stat), 2);
        step(3'b000, 0, 0, 0, 0);
        chk_clk("R4", 0, 0, int'(keep), 0);
        step(3'b000, 1, 0, 0, 0);
        chk("R7", "irq_req ignored in sleep", int'(mode_stat), 2);
        step(3'b011, 0, 0, 0, 0);
        chk("R9", "cmd dropped in sleep", int'(mode_stat), 2);
        step(3'b100, 0, 0, 0, 0);
        chk("R9", "soft reset dropped in sleep", int'(rst_active), 0);
        step(3'b000, 0, 1, 0, 0);
        chk("R7", "ext wakes sleep", int'(mode_stat), 0);
        step(3'b000, 0, 0, 0, 0);
        rtc_keep = 1'b1;
    endtask

    task automatic t_off(input logic keep, input logic use_wdt);
        rtc_keep = keep;
        step(3'b011, 0, 0, 0, 0);
        chk("R12", "off code", int'(mode_stat), 3);
        step(3'b000, 0, 0, 0, 0);
        chk_clk("R5", 0, 0, int'(keep), 1);
        step(3'b000, 1, 1, 0, 0);
        chk("R8", "irq ignored in off", int'(mode_stat), 3);
        step(3'b100, 0, 0, 0, 0);
        chk("R8", "soft reset ignored in off", int'(mode_stat), 3);
        chk("R8", "no rst_active in off", int'(rst_active), 0);
        step(3'b001, 0, 0, 0, 0);
        chk("R8", "cmd ignored in off", int'(mode_stat), 3);
        step(3'b000, 0, 0, !use_wdt, use_wdt);
        chk("R1", "reset leaves off", int'(mode_stat), 0);
        chk("R1", "rst_active set", int'(rst_active), 1);
        chk("R11", "cpu_en still off", int'(cpu_clk_en), 0);
        step(3'b000, 0, 0, 0, 0);
        chk_clk("R1", 1, 1, 1, 0);
        chk("R1", "rst_active clears", int'(rst_active), 0);
        rtc_keep = 1'b1;
    endtask

    task automatic t_cmds();
        step(3'b100, 0, 0, 0, 0);
        chk("R2", "soft reset rst_active", int'(rst_active), 1);
        chk("R2", "soft reset mode", int'(mode_stat), 0);
        for (int v = 5; v < 8; v++) begin
            step(3'(v), 0, 0, 0, 0);
            chk("R2", "unused code keeps mode", int'(mode_stat), 0);
            chk("R2", "unused code no reset", int'(rst_active), 0);
        end
    endtask

    task automatic t_race();
        step(3'b001, 1, 0, 0, 0);
        chk("R10", "irq beats idle entry", int'(mode_stat), 0);
        step(3'b010, 0, 1, 0, 0);
        chk("R10", "ext beats sleep entry", int'(mode_stat), 0);
        step(3'b011, 1, 0, 0, 0);
        chk("R10", "irq beats off entry", int'(mode_stat), 0);
        step(3'b001, 0, 0, 0, 0);
        step(3'b000, 1, 0, 1, 0);
        chk("R13", "reset with irq in idle", int'(mode_stat), 0);
        chk("R13", "reset with irq flag", int'(rst_active), 1);
        step(3'b010, 0, 0, 0, 1);
        chk("R13", "wdt beats sleep cmd", int'(mode_stat), 0);
        chk("R13", "wdt flag", int'(rst_active), 1);
        step(3'b000, 0, 0, 0, 0);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_idle();
                t_sleep(1'b1);
                t_sleep(1'b0);
                t_off(1'b1, 1'b0);
                t_off(1'b0, 1'b1);
                t_cmds();
                t_race();
            end
            begin
                repeat (5000) @(posedge clk);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule